// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block recovers characters from an asynchronous serial line. An external rate generator supplies a single-cycle `sampleTick` pulse at a fixed multiple (`OVERSAMPLE`, 16 by default) of the bit rate. The receiver brings the line into the clock domain through a two-stage synchronizer and waits in idle for a low level. It confirms the start bit at mid-bit and then samples every following bit at its centre. Before it accepts a character it checks the parity and the first stop bit.

Each character goes into a byte-wide receive buffer. Three sticky flags record parity, framing and overrun errors until the status is read. Every completed character produces a one-cycle receive interrupt. A configuration bit decides whether an error is reported only through that receive pulse or through a separate error interrupt. The surrounding bus logic turns register accesses into the `dataRead` and `statRead` strobes and supplies the configuration levels.

Top module: `uart_rx`

## Requirements
- R1: After reset, `rxData` is 0, `errStatus` is 0, and both `rxIrq` and `errIrq` are low.
- R2: A character is 8 data bits when `cfgLen8` is 1 and 7 data bits when it is 0. Bits arrive least significant first. In 7-bit mode `rxData[7]` reads 0.
- R3: `cfgParity` selects the parity mode: 2'b00 means no parity bit, 2'b01 means zero parity, 2'b10 means odd and 2'b11 means even. In odd or even mode, a parity bit that disagrees with the data sets `errStatus[2]`.
- R4: In zero-parity mode a parity bit is present on the line but is never checked, so `errStatus[2]` stays clear whatever its value.
- R5: A low first stop bit sets `errStatus[1]` (framing). When `cfgStop2` selects two stop bits, the second stop bit is waited out but is not checked.
- R6: If a character completes while the previous one has not been read with `dataRead`, `errStatus[0]` (overrun) is set and the new character replaces the buffer contents.
- R7: A `statRead` pulse clears all three flags. An error arriving in the same cycle is still recorded.
- R8: `rxIrq` is high for exactly one cycle each time a character is written into the buffer.
- R9: When a character completes with any error, `errIrq` pulses together with `rxIrq` if `cfgErrToRx` is 0. If `cfgErrToRx` is 1, `errIrq` stays low and the receive pulse alone reports the event.
- R10: Reception runs only while both `cfgClkEn` and `cfgRxEn` are 1. Otherwise the line is ignored and the buffer keeps its value.
- R11: A low level that has returned high by the mid-bit check of the start bit is rejected as a glitch: no character and no interrupt result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| cfgClkEn | input | 1 | Receiver clock enable |
| cfgRxEn | input | 1 | Receive enable |
| cfgLen8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgParity | input | 2 | Parity mode: none, zero, odd, even |
| cfgStop2 | input | 1 | 1: two stop bits, 0: one |
| cfgErrToRx | input | 1 | 1: errors reported through rxIrq only |
| dataRead | input | 1 | Strobe: buffer has been read |
| statRead | input | 1 | Strobe: status has been read (clears flags) |
| rxData | output | 8 | Receive buffer |
| errStatus | output | 3 | Sticky flags: [2] parity, [1] framing, [0] overrun |
| rxIrq | output | 1 | One-cycle receive-complete pulse |
| errIrq | output | 1 | One-cycle error pulse |

## Verification
The assertions assume the following about the inputs:
- The configuration levels stay constant while a character is being received.
- `dataRead` and `statRead` are single-cycle strobes.
- `sampleTick` never arrives faster than once every two clocks.

The stimulus respects all three. It changes configuration only after the line has been idle for at least two bit times. It pulses the read strobes for one cycle at the falling edge. It derives the tick from a divide-by-four counter. Each frame is driven with a whole number of bit periods, so that mid-bit sampling has a margin of several clocks.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } parModeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2
  } rxStateT;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic shiftBit;   // sample a data bit into the shifter
    logic capParity;  // sample the parity bit
    logic finish;     // sample first stop bit and commit the character
  } rxStrobeT;

  localparam int ERR_PARITY  = 2;
  localparam int ERR_FRAME   = 1;
  localparam int ERR_OVERRUN = 0;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleTick,
  input  logic     enable,
  input  logic     cfgLen8,
  input  logic     [1:0] cfgParity,
  input  logic     cfgStop2,
  input  logic     lineS,
  output rxStrobeT strb
);

  localparam int HALF = OVERSAMPLE / 2;
  localparam int CW   = $clog2(OVERSAMPLE + HALF);
  localparam logic [CW-1:0] CNT_MID   = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_FULL  = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] CNT_TAIL  = CW'(OVERSAMPLE + HALF - 1);

  rxStateT         state, stateN;
  logic [CW-1:0]   tickCnt, tickCntN;
  logic [2:0]      bitCnt, bitCntN;
  logic [2:0]      lastBit;

  assign lastBit = cfgLen8 ? 3'd7 : 3'd6;

  always_comb begin
    stateN   = state;
    tickCntN = tickCnt;
    bitCntN  = bitCnt;
    strb     = '0;
    if (!enable) begin
      stateN   = ST_IDLE;
      tickCntN = '0;
      bitCntN  = '0;
    end else if (sampleTick) begin
      tickCntN = tickCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          tickCntN = '0;
          if (!lineS) stateN = ST_START;
        end
        ST_START: begin
          if (tickCnt == CNT_MID) begin
            tickCntN = '0;
            bitCntN  = '0;
            stateN   = lineS ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (tickCnt == CNT_FULL) begin
            tickCntN      = '0;
            strb.shiftBit = 1'b1;
            if (bitCnt == lastBit)
              stateN = (parModeT'(cfgParity) == PAR_NONE) ? ST_STOP : ST_PAR;
            else
              bitCntN = bitCnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (tickCnt == CNT_FULL) begin
            tickCntN       = '0;
            strb.capParity = 1'b1;
            stateN         = ST_STOP;
          end
        end
        ST_STOP: begin
          if (tickCnt == CNT_FULL) begin
            tickCntN    = '0;
            strb.finish = 1'b1;
            stateN      = cfgStop2 ? ST_STOP2 : ST_IDLE;
          end
        end
        ST_STOP2: begin
          // wait to the end of the second stop bit, value ignored
          if (tickCnt == CNT_TAIL) begin
            tickCntN = '0;
            stateN   = ST_IDLE;
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateN;
      tickCnt <= tickCntN;
      bitCnt  <= bitCntN;
    end
  end

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              cfgLen8,
  input  logic [1:0]        cfgParity,
  input  logic              cfgErrToRx,
  input  logic              dataRead,
  input  logic              statRead,
  input  rxStrobeT          strb,
  output logic              lineS,
  output logic [DATA_W-1:0] rxData,
  output logic [2:0]        errStatus,
  output logic              rxIrq,
  output logic              errIrq
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DATA_W-1:0]      shiftReg;
  logic                   parBit;
  logic                   bufFull;
  logic [DATA_W-1:0]      charVal;
  logic                   parErr, frameErr, ovrErr;
  logic [2:0]             newErr;

  assign lineS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strb.shiftBit)  shiftReg <= {lineS, shiftReg[DATA_W-1:1]};
      if (strb.capParity) parBit   <= lineS;
    end
  end

  // 7-bit characters land one place high in the shifter
  assign charVal = cfgLen8 ? shiftReg : {1'b0, shiftReg[DATA_W-1:1]};

  always_comb begin
    unique case (parModeT'(cfgParity))
      PAR_ODD:  parErr = ~(^charVal ^ parBit);
      PAR_EVEN: parErr =  (^charVal ^ parBit);
      default:  parErr = 1'b0;
    endcase
  end

  assign frameErr = ~lineS;
  assign ovrErr   = bufFull & ~dataRead;

  always_comb begin
    newErr = '0;
    newErr[ERR_PARITY]  = parErr;
    newErr[ERR_FRAME]   = frameErr;
    newErr[ERR_OVERRUN] = ovrErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      bufFull   <= 1'b0;
      errStatus <= '0;
      rxIrq     <= 1'b0;
      errIrq    <= 1'b0;
    end else begin
      rxIrq  <= strb.finish;
      errIrq <= strb.finish & (|newErr) & ~cfgErrToRx;
      if (strb.finish) begin
        rxData    <= charVal;
        bufFull   <= 1'b1;
        errStatus <= (statRead ? 3'b000 : errStatus) | newErr;
      end else begin
        if (dataRead) bufFull   <= 1'b0;
        if (statRead) errStatus <= 3'b000;
      end
    end
  end

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic       cfgClkEn,
  input  logic       cfgRxEn,
  input  logic       cfgLen8,
  input  logic [1:0] cfgParity,
  input  logic       cfgStop2,
  input  logic       cfgErrToRx,
  input  logic       dataRead,
  input  logic       statRead,
  output logic [7:0] rxData,
  output logic [2:0] errStatus,
  output logic       rxIrq,
  output logic       errIrq
);

  rxStrobeT strb;
  logic     lineS;
  logic     enable;

  assign enable = cfgClkEn & cfgRxEn;

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .enable     (enable),
    .cfgLen8    (cfgLen8),
    .cfgParity  (cfgParity),
    .cfgStop2   (cfgStop2),
    .lineS      (lineS),
    .strb       (strb)
  );

  uart_rx_dp #(.DATA_W(8), .SYNC_STAGES(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .cfgLen8    (cfgLen8),
    .cfgParity  (cfgParity),
    .cfgErrToRx (cfgErrToRx),
    .dataRead   (dataRead),
    .statRead   (statRead),
    .strb       (strb),
    .lineS      (lineS),
    .rxData     (rxData),
    .errStatus  (errStatus),
    .rxIrq      (rxIrq),
    .errIrq     (errIrq)
  );

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgClkEn,
  input logic       cfgRxEn,
  input logic       cfgLen8,
  input logic       cfgErrToRx,
  input logic       statRead,
  input logic [7:0] rxData,
  input logic [2:0] errStatus,
  input logic       rxIrq,
  input logic       errIrq
);

  // R8: receive pulse lasts one cycle
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  // R9: error pulse only with a character and only when routed separately
  a_r9_err_route: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> (rxIrq && !cfgErrToRx));

  // R10: no character completes while disabled
  a_r10_gated: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgClkEn && cfgRxEn) |=> !rxIrq);

  // R7: status read leaves flags clear unless a character landed
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statRead ##1 !rxIrq) |-> (errStatus == 3'b000));

  // R6: flags stay set until a status read
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errStatus[0] && !statRead) |=> errStatus[0]);

  // R2: in 7-bit mode the top buffer bit is zero
  a_r2_len7_msb: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq && !cfgLen8) |-> !rxData[7]);

endmodule

bind uart_rx uart_rx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgClkEn   (cfgClkEn),
  .cfgRxEn    (cfgRxEn),
  .cfgLen8    (cfgLen8),
  .cfgErrToRx (cfgErrToRx),
  .statRead   (statRead),
  .rxData     (rxData),
  .errStatus  (errStatus),
  .rxIrq      (rxIrq),
  .errIrq     (errIrq)
);

// File: tb/uart_rx_tb.sv
module uart_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OS         = 16;
  localparam int BIT_CLKS   = TICK_DIV * OS;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       cfgClkEn = 1'b1, cfgRxEn = 1'b1, cfgLen8 = 1'b1;
  logic [1:0] cfgParity = 2'b00;
  logic       cfgStop2 = 1'b0, cfgErrToRx = 1'b0;
  logic       dataRead = 1'b0, statRead = 1'b0;
  logic [7:0] rxData;
  logic [2:0] errStatus;
  logic       rxIrq, errIrq;

  int errors = 0;
  int checks = 0;
  int rxCnt = 0;
  int errCnt = 0;
  int divCnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx #(.OVERSAMPLE(OS)) u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .cfgClkEn(cfgClkEn), .cfgRxEn(cfgRxEn), .cfgLen8(cfgLen8),
    .cfgParity(cfgParity), .cfgStop2(cfgStop2), .cfgErrToRx(cfgErrToRx),
    .dataRead(dataRead), .statRead(statRead), .rxData(rxData),
    .errStatus(errStatus), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  always @(posedge clk) begin
    divCnt     <= (divCnt == TICK_DIV-1) ? 0 : divCnt + 1;
    sampleTick <= (divCnt == TICK_DIV-1);
    if (rxIrq)  rxCnt  <= rxCnt + 1;
    if (errIrq) errCnt <= errCnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic b);
    rxLine = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit badPar,
                           input bit badStop1, input bit badStop2);
    int n;
    logic p;
    n = cfgLen8 ? 8 : 7;
    driveBit(1'b0);
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      driveBit(d[i]);
      p ^= d[i];
    end
    if (cfgParity != 2'b00) begin
      if (cfgParity == 2'b01)      p = 1'b0;
      else if (cfgParity == 2'b10) p = ~p;
      driveBit(p ^ badPar);
    end
    driveBit(~badStop1);
    if (cfgStop2) driveBit(~badStop2);
    driveBit(1'b1);
    driveBit(1'b1);
  endtask

  task automatic readAll();
    @(negedge clk);
    dataRead = 1'b1; statRead = 1'b1;
    @(negedge clk);
    dataRead = 1'b0; statRead = 1'b0;
    @(negedge clk);
  endtask

  task automatic runFrame(input logic [7:0] d, input bit badPar,
                          input bit badStop1, input bit badStop2);
    int rx0, er0;
    logic [7:0] expData;
    bit pe, fe;
    string stTag;
    rx0 = rxCnt; er0 = errCnt;
    sendFrame(d, badPar, badStop1, badStop2);
    expData = cfgLen8 ? d : {1'b0, d[6:0]};
    pe = badPar && (cfgParity == 2'b10 || cfgParity == 2'b11);
    fe = badStop1;
    if (badPar && cfgParity == 2'b01) stTag = "R4 zero parity unchecked";
    else if (badStop1 || badStop2)    stTag = "R5 stop check";
    else                              stTag = "R3 parity status";
    check("R2 data", int'(rxData), int'(expData));
    check(stTag, int'(errStatus), int'({pe, fe, 1'b0}));
    check("R8 one rx pulse", rxCnt - rx0, 1);
    check("R9 error pulse routing", errCnt - er0,
          ((pe || fe) && !cfgErrToRx) ? 1 : 0);
    readAll();
    check("R7 status cleared", int'(errStatus), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] held;
    int rx0, er0;
    repeat (5) @(negedge clk);
    // R1: reset values
    check("R1 reset data", int'(rxData), 0);
    check("R1 reset status", int'(errStatus), 0);
    check("R1 reset irqs", int'({rxIrq, errIrq}), 0);
    rstN = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // sweep: length x parity x stops x injected fault
    for (int ln = 0; ln < 2; ln++)
      for (int pm = 0; pm < 4; pm++)
        for (int s2 = 0; s2 < 2; s2++)
          for (int inj = 0; inj < 4; inj++) begin
            if (inj == 1 && pm == 0) continue;
            if (inj == 3 && s2 == 0) continue;
            cfgLen8    = ln[0];
            cfgParity  = pm[1:0];
            cfgStop2   = s2[0];
            cfgErrToRx = inj[0] ^ pm[0];
            d = 8'h5A + 8'(37 * (pm*8 + s2*4 + inj + ln*32));
            runFrame(d, inj == 1, inj == 2, inj == 3);
          end

    // R6: overrun, second character replaces the first
    cfgLen8 = 1'b1; cfgParity = 2'b11; cfgStop2 = 1'b0; cfgErrToRx = 1'b0;
    er0 = errCnt;
    sendFrame(8'hC3, 1'b0, 1'b0, 1'b0);
    sendFrame(8'h3C, 1'b0, 1'b0, 1'b0);
    check("R6 overrun flag", int'(errStatus), 1);
    check("R6 overwrite", int'(rxData), 8'h3C);
    check("R9 overrun error pulse", errCnt - er0, 1);
    readAll();
    check("R7 clear after overrun", int'(errStatus), 0);

    // R6 with routing to rx: no error pulse
    cfgErrToRx = 1'b1;
    er0 = errCnt; rx0 = rxCnt;
    sendFrame(8'h11, 1'b0, 1'b0, 1'b0);
    sendFrame(8'h22, 1'b0, 1'b0, 1'b0);
    check("R6 overrun routed", int'(errStatus), 1);
    check("R9 no error pulse when routed", errCnt - er0, 0);
    check("R8 two rx pulses", rxCnt - rx0, 2);
    readAll();

    // R11: short low glitch rejected
    held = rxData; rx0 = rxCnt;
    @(negedge clk);
    rxLine = 1'b0;
    repeat (5 * TICK_DIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R11 glitch no pulse", rxCnt - rx0, 0);
    check("R11 glitch buffer kept", int'(rxData), int'(held));
    check("R11 glitch no status", int'(errStatus), 0);
    // receiver still works after the glitch
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b0);
    check("R11 frame after glitch", int'(rxData), 8'hA5);
    readAll();

    // R10: receive enable low, then clock enable low
    held = rxData; rx0 = rxCnt;
    cfgRxEn = 1'b0;
    sendFrame(8'h69, 1'b0, 1'b0, 1'b0);
    check("R10 rx disabled no pulse", rxCnt - rx0, 0);
    check("R10 rx disabled buffer kept", int'(rxData), int'(held));
    cfgRxEn = 1'b1; cfgClkEn = 1'b0;
    sendFrame(8'h96, 1'b1, 1'b1, 1'b0);
    check("R10 clk disabled no pulse", rxCnt - rx0, 0);
    check("R10 clk disabled status", int'(errStatus), 0);
    cfgClkEn = 1'b1;
    sendFrame(8'h96, 1'b0, 1'b0, 1'b0);
    check("R10 re-enabled", int'(rxData), 8'h96);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule